// File: doc/BRIEF.md
# Four-operand saturating adder

This block adds four signed operands of equal width and returns one resolved, saturated result. A typical use is the stage that combines the quantized outputs of several parallel subfilters in a fractional-delay filter. One resolved bus leaves the block, so a constant multiplier placed after it is built once, not once per half of a redundant pair.

Each operand is sign-extended by two guard bits, which is enough headroom for the exact sum of four values. Two cascaded 3:2 carry-save stages reduce the four extended operands to a sum vector and a carry vector. Before it enters the next stage, each carry vector is moved up one bit position. A carry-lookahead adder, built from four-bit lookahead groups, resolves the pair. A clamp stage then fits the exact sum into the output width and raises a flag whenever it has to limit the value.

The operand width is set by the caller to the widest of the incoming buses. An optional register between the carry-save stages and the lookahead adder shortens the critical path at the cost of one cycle of latency.

Top module: `quad_sat_adder`

## Requirements
- R1: The internal sum is exact for any four operands, including combinations whose partial sums leave the operand range (for example 127 + 127 + (-128) + (-100) gives 26 with 8-bit operands).
- R2: When the exact sum lies within the signed output range, `sum_o` equals it as a two's-complement value of `OUT_W` bits.
- R3: When the exact sum exceeds the largest output code, `sum_o` is 0 followed by all ones (255 for `OUT_W` = 9) and `clip_o` is 1.
- R4: When the exact sum is below the smallest output code, `sum_o` is 1 followed by all zeros (-256 for `OUT_W` = 9) and `clip_o` is 1.
- R5: `clip_o` is 0 for every sum inside the output range, including sums equal to the largest or the smallest code.
- R6: Every cycle with `in_valid_i` high yields exactly one cycle with `out_valid_o` high, 1 + `PIPE_MID` cycles later and in issue order. Back-to-back inputs give back-to-back results.
- R7: When `out_valid_o` is low, `sum_o` and `clip_o` keep the value of the last valid result.
- R8: While `rst_ni` is low, `out_valid_o`, `sum_o` and `clip_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | The four operands are valid this cycle |
| a_i | input | IN_W | Signed operand 0 |
| b_i | input | IN_W | Signed operand 1 |
| c_i | input | IN_W | Signed operand 2 |
| d_i | input | IN_W | Signed operand 3 |
| out_valid_o | output | 1 | `sum_o` and `clip_o` carry a new result |
| sum_o | output | OUT_W | Saturated signed sum |
| clip_o | output | 1 | The result was limited to an end of the output range |

## Verification
The bench builds the block with `IN_W` = 8, `OUT_W` = 9 and `PIPE_MID` = 1. An output one bit wider than an operand lets two near-maximum or two near-minimum operands reach each clamp, and it also leaves exact in-range sums whose 8-bit partial sums wrap. The mid-path register gives a two-cycle latency, so a back-to-back stream keeps two results in flight, and the order and latency checks see real overlap. The internal width of ten bits ends in a partial lookahead group, which tests the group carry chain at its ragged top end.

// File: rtl/quad_sat_adder_pkg.sv
package quad_sat_adder_pkg;
   // headroom needed for the exact sum of four operands
   localparam int GUARD_BITS = 2;
   // bits resolved by one lookahead group in the final adder
   localparam int LOOKAHEAD_GROUP = 4;
endpackage

// File: rtl/qsa_csa.sv
module qsa_csa #(
   parameter int W = 10
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic [W-1:0] z_i,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] cy_o
);
   // bitwise sum; majority carries, already moved up one place
   assign sum_o = x_i ^ y_i ^ z_i;
   assign cy_o[0] = 1'b0;
   for (genvar i = 0; i < W - 1; i++) begin : g_maj
      assign cy_o[i+1] = (x_i[i] & y_i[i]) | (x_i[i] & z_i[i]) | (y_i[i] & z_i[i]);
   end
endmodule

// File: rtl/qsa_cla.sv
module qsa_cla
   import quad_sat_adder_pkg::*;
#(
   parameter int W = 10
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] sum_o
);
   localparam int G  = LOOKAHEAD_GROUP;
   localparam int NG = (W + G - 1) / G;

   logic [W-1:0] prop, gen;
   assign prop = x_i ^ y_i;
   assign gen  = x_i & y_i;

   // each carry is a flat generate/propagate term from its group's carry-in
   always_comb begin
      logic grp_in, grp_next, cj, accp;
      int   idx;
      grp_in   = 1'b0;
      grp_next = 1'b0;
      sum_o    = '0;
      for (int k = 0; k < NG; k++) begin
         grp_next = 1'b0;
         for (int j = 0; j <= G; j++) begin
            if (k * G + j <= W) begin
               cj   = 1'b0;
               accp = 1'b1;
               for (int t = G - 1; t >= 0; t--) begin
                  if (t < j) begin
                     idx  = k * G + t;
                     cj   = cj | (accp & gen[idx]);
                     accp = accp & prop[idx];
                  end
               end
               cj = cj | (accp & grp_in);
               if (j < G && k * G + j < W) sum_o[k*G+j] = prop[k*G+j] ^ cj;
               if (j == G) grp_next = cj;
            end
         end
         grp_in = grp_next;
      end
   end
endmodule

// File: rtl/qsa_clamp.sv
module qsa_clamp #(
   parameter int IW = 10,
   parameter int OW = 9
) (
   input  logic [IW-1:0] val_i,
   output logic [OW-1:0] res_o,
   output logic          clip_o
);
   if (OW < IW) begin : g_narrow
      logic [IW-OW:0] top;
      logic           fits;
      assign top    = val_i[IW-1:OW-1];
      assign fits   = (&top) | ~(|top);
      assign clip_o = ~fits;
      assign res_o  = fits       ? val_i[OW-1:0] :
                      val_i[IW-1] ? {1'b1, {(OW-1){1'b0}}} :
                                    {1'b0, {(OW-1){1'b1}}};
   end else if (OW == IW) begin : g_equal
      assign res_o  = val_i;
      assign clip_o = 1'b0;
   end else begin : g_wide
      assign res_o  = {{(OW-IW){val_i[IW-1]}}, val_i};
      assign clip_o = 1'b0;
   end
endmodule

// File: rtl/quad_sat_adder.sv
module quad_sat_adder
   import quad_sat_adder_pkg::*;
#(
   parameter int IN_W     = 8,
   parameter int OUT_W    = 9,
   parameter bit PIPE_MID = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             in_valid_i,
   input  logic [IN_W-1:0]  a_i,
   input  logic [IN_W-1:0]  b_i,
   input  logic [IN_W-1:0]  c_i,
   input  logic [IN_W-1:0]  d_i,
   output logic             out_valid_o,
   output logic [OUT_W-1:0] sum_o,
   output logic             clip_o
);
   localparam int IW  = IN_W + GUARD_BITS;
   localparam int LAT = 1 + int'(PIPE_MID);

   if (IN_W < 2) begin : g_bad_in
      $error("quad_sat_adder: IN_W must be at least 2");
   end
   if (OUT_W < 2) begin : g_bad_out
      $error("quad_sat_adder: OUT_W must be at least 2");
   end

   // guard-bit extension
   logic [IW-1:0] ax, bx, cx, dx;
   assign ax = {{GUARD_BITS{a_i[IN_W-1]}}, a_i};
   assign bx = {{GUARD_BITS{b_i[IN_W-1]}}, b_i};
   assign cx = {{GUARD_BITS{c_i[IN_W-1]}}, c_i};
   assign dx = {{GUARD_BITS{d_i[IN_W-1]}}, d_i};

   // two cascaded 3:2 reductions
   logic [IW-1:0] s1, k1, s2, k2;
   qsa_csa #(.W(IW)) u_csa_lo (.x_i(ax), .y_i(bx), .z_i(cx), .sum_o(s1), .cy_o(k1));
   qsa_csa #(.W(IW)) u_csa_hi (.x_i(s1), .y_i(k1), .z_i(dx), .sum_o(s2), .cy_o(k2));

   // optional register on the redundant pair
   logic [IW-1:0] s2_m, k2_m;
   logic          v_m;
   if (PIPE_MID) begin : g_mid_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            s2_m <= '0;
            k2_m <= '0;
            v_m  <= 1'b0;
         end else begin
            v_m <= in_valid_i;
            if (in_valid_i) begin
               s2_m <= s2;
               k2_m <= k2;
            end
         end
      end
   end else begin : g_mid_wire
      assign s2_m = s2;
      assign k2_m = k2;
      assign v_m  = in_valid_i;
   end

   // resolve, then fit into the output width
   logic [IW-1:0]    total;
   logic [OUT_W-1:0] fitted;
   logic             clip_c;
   qsa_cla   #(.W(IW))              u_cla   (.x_i(s2_m), .y_i(k2_m), .sum_o(total));
   qsa_clamp #(.IW(IW), .OW(OUT_W)) u_clamp (.val_i(total), .res_o(fitted), .clip_o(clip_c));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_valid_o <= 1'b0;
         sum_o       <= '0;
         clip_o      <= 1'b0;
      end else begin
         out_valid_o <= v_m;
         if (v_m) begin
            sum_o  <= fitted;
            clip_o <= clip_c;
         end
      end
   end
endmodule

// File: rtl/quad_sat_adder_chk.sv
module quad_sat_adder_chk #(
   parameter int OUT_W = 9,
   parameter int LAT   = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             out_valid,
   input logic [OUT_W-1:0] sum,
   input logic             clip
);
   localparam logic [OUT_W-1:0] TOP_CODE = {1'b0, {(OUT_W-1){1'b1}}};
   localparam logic [OUT_W-1:0] BOT_CODE = {1'b1, {(OUT_W-1){1'b0}}};

   // edges seen since reset release, saturating
   logic [2:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) warm <= '0;
      else if (warm != 3'd7) warm <= warm + 3'd1;
   end

   // R6: a result appears exactly LAT cycles after each accepted input
   a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(warm) > LAT) |-> (out_valid == $past(in_valid, LAT)));

   // R3 and R4: a raised flag always comes with an end-of-range code
   a_r3_r4_clip_code: assert property (@(posedge clk) disable iff (!rst_n)
      clip |-> (sum == TOP_CODE || sum == BOT_CODE));

   // R7: the result holds while no new result is presented
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(sum) && $stable(clip)));

   // R8: outputs are cleared while reset is held
   always @(negedge clk) begin
      if (!rst_n) begin
         a_r8_reset: assert (!out_valid && !clip && sum == '0);
      end
   end
endmodule

bind quad_sat_adder quad_sat_adder_chk #(.OUT_W(OUT_W), .LAT(LAT)) u_chk (
   .clk(clk_i), .rst_n(rst_ni), .in_valid(in_valid_i),
   .out_valid(out_valid_o), .sum(sum_o), .clip(clip_o)
);

// File: tb/quad_sat_adder_test.sv
`timescale 1ns/1ps
module quad_sat_adder_test;
   localparam int IN_W  = 8;
   localparam int OUT_W = 9;
   localparam int LAT   = 2;
   localparam int TOPV  = (1 << (OUT_W - 1)) - 1;
   localparam int BOTV  = -(1 << (OUT_W - 1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [IN_W-1:0] a = '0, b = '0, c = '0, d = '0;
   logic out_valid, clip;
   logic [OUT_W-1:0] sum;

   always #2.5 clk = ~clk;

   quad_sat_adder #(.IN_W(IN_W), .OUT_W(OUT_W), .PIPE_MID(1'b1)) uut (
      .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid),
      .a_i(a), .b_i(b), .c_i(c), .d_i(d),
      .out_valid_o(out_valid), .sum_o(sum), .clip_o(clip)
   );

   typedef struct {
      int    val;
      bit    clp;
      int    cyc;
      string tag;
   } item_t;

   item_t exp_q[$];
   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;
   bit seen = 1'b0;
   int last_val = 0;
   bit last_clp = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, expv);
      end
   endtask

   // driver: applies operands and records the expected result
   task automatic drive(int av, int bv, int cv, int dv, string tag);
      item_t it;
      int    tot;
      @(negedge clk);
      a = IN_W'(av); b = IN_W'(bv); c = IN_W'(cv); d = IN_W'(dv);
      in_valid = 1'b1;
      tot = av + bv + cv + dv;
      it.clp = (tot > TOPV) || (tot < BOTV);
      it.val = (tot > TOPV) ? TOPV : (tot < BOTV) ? BOTV : tot;
      it.cyc = cyc;
      it.tag = it.clp ? ((tot > TOPV) ? "R3" : "R4") : tag;
      exp_q.push_back(it);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // monitor: compares each result against the queue head
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R6", 1, 0);
            end else begin
               item_t it;
               int    act;
               it = exp_q.pop_front();
               act = int'($signed(sum));
               check(act == it.val, it.tag, act, it.val);
               check(clip == it.clp, it.clp ? it.tag : "R5", int'(clip), int'(it.clp));
               check(cyc - it.cyc == LAT, "R6", cyc - it.cyc, LAT);
               last_val = act;
               last_clp = clip;
               seen = 1'b1;
            end
         end else if (seen) begin
            check(int'($signed(sum)) == last_val, "R7", int'($signed(sum)), last_val);
            check(clip == last_clp, "R7", int'(clip), int'(last_clp));
         end
      end
   end

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      check(out_valid == 1'b0, "R8", int'(out_valid), 0);
      check(sum == '0, "R8", int'(sum), 0);
      check(clip == 1'b0, "R8", int'(clip), 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R2: plain in-range sums
      drive(1, 2, 3, 4, "R2");
      drive(-5, 3, -7, 2, "R2");
      idle(3);
      // R1: partial sums leave the operand range, total does not
      drive(127, 127, -128, -100, "R1");
      drive(-128, -128, 127, 127, "R1");
      drive(100, 100, 100, -128, "R1");
      idle(2);
      // R3 and R5: top of the range
      drive(127, 127, 127, 127, "R3");
      drive(127, 127, 2, 0, "R3");
      drive(127, 127, 1, 0, "R5");
      idle(4);
      // R4 and R5: bottom of the range
      drive(-128, -128, -128, -128, "R4");
      drive(-128, -128, -1, 0, "R4");
      drive(-128, -128, 0, 0, "R5");
      idle(3);
      // R6: long back-to-back random stream
      for (int i = 0; i < 60; i++) begin
         drive(int'($signed(IN_W'($urandom))), int'($signed(IN_W'($urandom))),
               int'($signed(IN_W'($urandom))), int'($signed(IN_W'($urandom))), "R2");
      end
      // R7: sparse stream with gaps
      for (int i = 0; i < 20; i++) begin
         drive(int'($signed(IN_W'($urandom))), int'($signed(IN_W'($urandom))),
               int'($signed(IN_W'($urandom))), int'($signed(IN_W'($urandom))), "R2");
         idle(1 + (i % 3));
      end
      idle(6);
      check(exp_q.size() == 0, "R6", exp_q.size(), 0);
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
         summary();
      end
   end
endmodule